// File: doc/BRIEF.md
# Dual-View I/O Register Space

This block holds the 64-location, byte-wide I/O register space of a small 8-bit microcontroller. A single byte port reaches it through one of two address views. In the I/O view the address is the register's own location. In the data-space view the same registers appear 0x20 higher, so data-space addresses 0x20–0x5F alias I/O locations 0x00–0x3F. A second port performs single-bit set, clear and test operations, and it works only on the lower 32 locations.

Five locations are populated. Three general-purpose storage registers keep any byte written to them. A status register holds eight flags: hardware event inputs set them, and writing a one clears them. An EEPROM address high register keeps only its least significant bit, and a parameter can remove that bit for the smaller-memory variant. Every other location is unmapped. Reads and bit tests are combinational. Writes and bit updates take effect at the next rising clock edge.

Top module: `ioreg_space`

## Requirements
- R1: After reset the three general-purpose registers and the status register read 0x00.
- R2: With `byteView`=0 the byte port addresses I/O location `byteAddr[5:0]`. Any address with `byteAddr[6]`=1 is unmapped.
- R3: With `byteView`=1, byte addresses 0x20–0x5F reach I/O location `byteAddr`−0x20. Byte addresses below 0x20 or above 0x5F are unmapped.
- R4: Writes to unmapped locations are discarded, and reads of them return 0x00. With default parameters the mapped I/O locations are: general-purpose registers at 0x13, 0x2A and 0x2B, the status register at 0x1C, and the EEPROM address high register at 0x1F.
- R5: A general-purpose register returns the last byte written to it. `byteRdata` shows the addressed register in the same cycle and shows a write from the next cycle on.
- R6: `bitOp` encodes 2'b00 none, 2'b01 set, 2'b10 clear and 2'b11 test. Set and clear change only bit `bitIdx` of the register at `bitAddr`, at the next edge. A test drives `bitResult` with that bit in the same cycle, and `bitResult` is 0 otherwise.
- R7: A bit operation with `bitAddr` ≥ 0x20 changes nothing, and a test at such an address returns 0.
- R8: A byte write to the status register clears each flag written with 1 and leaves flags written with 0 unchanged. A bit-set operation clears only the selected flag. A bit-clear operation has no effect on it.
- R9: `flagEvent[k]`=1 sets status flag k at the next edge. This holds even when a clear of that flag arrives in the same cycle.
- R10: The EEPROM address high register reads bits 7:1 as 0. Bit 0 is written by byte writes and bit operations. With `SMALL_EE`=1 the whole register reads 0x00.
- R11: When a byte write and a bit set or clear hit the same register in the same cycle, the register takes the byte value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| byteEn | input | 1 | Byte port access enable |
| byteWe | input | 1 | Byte port write (1) or read (0) |
| byteView | input | 1 | 0 = I/O view address, 1 = data-space view address |
| byteAddr | input | 7 | Byte port address |
| byteWdata | input | 8 | Byte write data |
| byteRdata | output | 8 | Byte read data, 0x00 when unmapped or not enabled |
| bitEn | input | 1 | Bit port enable |
| bitOp | input | 2 | Bit operation code |
| bitAddr | input | 6 | Bit port I/O address |
| bitIdx | input | 3 | Bit index within the register |
| bitResult | output | 1 | Bit test result |
| flagEvent | input | 8 | Hardware events that set status flags |

## Verification
Reads on `byteRdata` and bit tests on `bitResult` are due in the same cycle as the request. Byte writes, bit set and clear, and flag events first become visible in the cycle after the rising edge that captures them. The bench therefore changes inputs on the falling edge. It samples combinational results 1 ns later, within that same cycle. It checks the effect of a write with a read in the next cycle, after the capturing edge.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;

  localparam int NREG = 5;
  localparam int REG_STAT = 3;
  localparam int REG_EEH = 4;

  typedef enum logic [1:0] {
    BOP_NONE = 2'b00,
    BOP_SET  = 2'b01,
    BOP_CLR  = 2'b10,
    BOP_TEST = 2'b11
  } bitop_e;

  typedef struct packed {
    logic [NREG-1:0] byteWr;
    logic [NREG-1:0] byteRd;
    logic [NREG-1:0] bitSet;
    logic [NREG-1:0] bitClr;
    logic [NREG-1:0] bitRd;
    logic [7:0]      bitMask;
  } strobe_t;

endpackage

// File: rtl/ioreg_ctrl.sv
module ioreg_ctrl
  import ioreg_pkg::*;
#(
  parameter logic [6*NREG-1:0] REG_ADDRS = {6'h1F, 6'h1C, 6'h2B, 6'h2A, 6'h13}
) (
  input  logic       byteEn,
  input  logic       byteWe,
  input  logic       byteView,
  input  logic [6:0] byteAddr,
  input  logic       bitEn,
  input  logic [1:0] bitOp,
  input  logic [5:0] bitAddr,
  input  logic [2:0] bitIdx,
  output strobe_t    st
);

  localparam logic [6:0] DS_BASE = 7'h20;
  localparam logic [6:0] DS_END  = 7'h60;

  bitop_e          opCode;
  logic [5:0]      ioAddr;
  logic            byteMapped;
  logic            bitOk;
  logic [NREG-1:0] wrVec, rdVec, setVec, clrVec, tstVec;

  assign opCode = bitop_e'(bitOp);

  always_comb begin
    if (byteView) begin
      byteMapped = (byteAddr >= DS_BASE) && (byteAddr < DS_END);
      ioAddr     = 6'(byteAddr - DS_BASE);
    end else begin
      byteMapped = !byteAddr[6];
      ioAddr     = byteAddr[5:0];
    end
  end

  // bit port only reaches the lower half of the space
  assign bitOk = bitEn && !bitAddr[5];

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam logic [5:0] LOC = REG_ADDRS[6*i +: 6];
    logic byteHit, bitHit;
    assign byteHit   = byteEn && byteMapped && (ioAddr == LOC);
    assign bitHit    = bitOk && (bitAddr == LOC);
    assign wrVec[i]  = byteHit && byteWe;
    assign rdVec[i]  = byteHit;
    // byte port has priority over a bit update of the same register
    assign setVec[i] = bitHit && (opCode == BOP_SET) && !wrVec[i];
    assign clrVec[i] = bitHit && (opCode == BOP_CLR) && !wrVec[i];
    assign tstVec[i] = bitHit && (opCode == BOP_TEST);
  end

  assign st.byteWr  = wrVec;
  assign st.byteRd  = rdVec;
  assign st.bitSet  = setVec;
  assign st.bitClr  = clrVec;
  assign st.bitRd   = tstVec;
  assign st.bitMask = 8'b1 << bitIdx;

endmodule

// File: rtl/ioreg_dp.sv
module ioreg_dp
  import ioreg_pkg::*;
#(
  parameter bit   SMALL_EE    = 1'b0,
  parameter logic EE_MSB_INIT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    st,
  input  logic [7:0] byteWdata,
  input  logic [7:0] flagEvent,
  output logic [7:0] byteRdata,
  output logic       bitResult
);

  logic [7:0] regVal [NREG];

  // general-purpose storage registers
  for (genvar g = 0; g < REG_STAT; g++) begin : g_gpr
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              q <= '0;
      else if (st.byteWr[g])  q <= byteWdata;
      else if (st.bitSet[g])  q <= q | st.bitMask;
      else if (st.bitClr[g])  q <= q & ~st.bitMask;
    end
    assign regVal[g] = q;
  end

  // status flags: write one to clear, events set and win
  logic [7:0] statQ, statClr;
  logic       unusedStatClr;
  always_comb begin
    if (st.byteWr[REG_STAT])      statClr = byteWdata;
    else if (st.bitSet[REG_STAT]) statClr = st.bitMask;
    else                          statClr = '0;
  end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~statClr) | flagEvent;
  end
  assign regVal[REG_STAT] = statQ;
  // writing zero to a flag does nothing, so bit-clear is a no-op here
  assign unusedStatClr = st.bitClr[REG_STAT];

  // EEPROM address high: only the MSB of the address is kept
  if (!SMALL_EE) begin : g_eeMsb
    logic msbQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    msbQ <= EE_MSB_INIT;
      else if (st.byteWr[REG_EEH])                  msbQ <= byteWdata[0];
      else if (st.bitSet[REG_EEH] && st.bitMask[0]) msbQ <= 1'b1;
      else if (st.bitClr[REG_EEH] && st.bitMask[0]) msbQ <= 1'b0;
    end
    assign regVal[REG_EEH] = {7'b0, msbQ};
  end else begin : g_eeNone
    logic unusedEe;
    assign unusedEe = ^{st.byteWr[REG_EEH], st.bitSet[REG_EEH], st.bitClr[REG_EEH]};
    assign regVal[REG_EEH] = '0;
  end

  always_comb begin
    byteRdata = '0;
    bitResult = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (st.byteRd[i]) byteRdata = byteRdata | regVal[i];
      if (st.bitRd[i])  bitResult = bitResult | (|(regVal[i] & st.bitMask));
    end
  end

endmodule

// File: rtl/ioreg_space.sv
module ioreg_space
  import ioreg_pkg::*;
#(
  parameter logic [17:0] GPR_ADDRS   = {6'h2B, 6'h2A, 6'h13},
  parameter logic [5:0]  STAT_ADDR   = 6'h1C,
  parameter logic [5:0]  EEH_ADDR    = 6'h1F,
  parameter bit          SMALL_EE    = 1'b0,
  parameter logic        EE_MSB_INIT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteEn,
  input  logic       byteWe,
  input  logic       byteView,
  input  logic [6:0] byteAddr,
  input  logic [7:0] byteWdata,
  output logic [7:0] byteRdata,
  input  logic       bitEn,
  input  logic [1:0] bitOp,
  input  logic [5:0] bitAddr,
  input  logic [2:0] bitIdx,
  output logic       bitResult,
  input  logic [7:0] flagEvent
);

  localparam logic [6*NREG-1:0] REG_ADDRS = {EEH_ADDR, STAT_ADDR, GPR_ADDRS};

  strobe_t st;

  ioreg_ctrl #(.REG_ADDRS(REG_ADDRS)) u_ctrl (
    .byteEn   (byteEn),
    .byteWe   (byteWe),
    .byteView (byteView),
    .byteAddr (byteAddr),
    .bitEn    (bitEn),
    .bitOp    (bitOp),
    .bitAddr  (bitAddr),
    .bitIdx   (bitIdx),
    .st       (st)
  );

  ioreg_dp #(.SMALL_EE(SMALL_EE), .EE_MSB_INIT(EE_MSB_INIT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .byteWdata (byteWdata),
    .flagEvent (flagEvent),
    .byteRdata (byteRdata),
    .bitResult (bitResult)
  );

endmodule

// File: rtl/ioreg_space_chk.sv
module ioreg_space_chk #(
  parameter logic [17:0] GPR_ADDRS = {6'h2B, 6'h2A, 6'h13},
  parameter logic [5:0]  STAT_ADDR = 6'h1C,
  parameter logic [5:0]  EEH_ADDR  = 6'h1F,
  parameter bit          SMALL_EE  = 1'b0
) (
  input logic       clk,
  input logic       rstN,
  input logic       byteEn,
  input logic       byteWe,
  input logic       byteView,
  input logic [6:0] byteAddr,
  input logic [7:0] byteWdata,
  input logic [7:0] byteRdata,
  input logic       bitEn,
  input logic [5:0] bitAddr,
  input logic       bitResult,
  input logic [7:0] flagEvent
);

  logic [6:0] gpr0Io, statIo, eehIo;
  assign gpr0Io = {1'b0, GPR_ADDRS[5:0]};
  assign statIo = {1'b0, STAT_ADDR};
  assign eehIo  = {1'b0, EEH_ADDR};

  AST_UNMAPPED_DS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (byteEn && byteView && (byteAddr < 7'h20 || byteAddr >= 7'h60)) |-> byteRdata == 8'h00); // R3

  AST_HIGH_IO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (byteEn && !byteView && byteAddr[6]) |-> byteRdata == 8'h00); // R2

  AST_HIGH_BIT_TEST_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && bitAddr[5]) |-> !bitResult); // R7

  AST_GPR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (byteEn && byteWe && !byteView && byteAddr == gpr0Io) |=>
      (!(byteEn && !byteView && byteAddr == gpr0Io) || byteRdata == $past(byteWdata))); // R5

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|flagEvent) |=>
      (!(byteEn && !byteView && byteAddr == statIo) ||
       ((byteRdata & $past(flagEvent)) == $past(flagEvent)))); // R9

  AST_EEH_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (byteEn && !byteView && byteAddr == eehIo) |->
      (byteRdata[7:1] == 7'b0 && (!SMALL_EE || byteRdata[0] == 1'b0))); // R10

endmodule

bind ioreg_space ioreg_space_chk #(
  .GPR_ADDRS (GPR_ADDRS),
  .STAT_ADDR (STAT_ADDR),
  .EEH_ADDR  (EEH_ADDR),
  .SMALL_EE  (SMALL_EE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .byteEn    (byteEn),
  .byteWe    (byteWe),
  .byteView  (byteView),
  .byteAddr  (byteAddr),
  .byteWdata (byteWdata),
  .byteRdata (byteRdata),
  .bitEn     (bitEn),
  .bitAddr   (bitAddr),
  .bitResult (bitResult),
  .flagEvent (flagEvent)
);

// File: tb/ioreg_space_test.sv
`timescale 1ns/1ps
module ioreg_space_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteEn = 1'b0, byteWe = 1'b0, byteView = 1'b0;
  logic [6:0] byteAddr = '0;
  logic [7:0] byteWdata = '0;
  logic [7:0] byteRdata, smallRdata;
  logic       bitEn = 1'b0;
  logic [1:0] bitOp = 2'b00;
  logic [5:0] bitAddr = '0;
  logic [2:0] bitIdx = '0;
  logic       bitResult, smallBit;
  logic [7:0] flagEvent = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] OP_SET = 2'b01, OP_CLR = 2'b10, OP_TEST = 2'b11;

  always #2 clk = ~clk;

  ioreg_space uut (
    .clk(clk), .rstN(rstN), .byteEn(byteEn), .byteWe(byteWe), .byteView(byteView),
    .byteAddr(byteAddr), .byteWdata(byteWdata), .byteRdata(byteRdata),
    .bitEn(bitEn), .bitOp(bitOp), .bitAddr(bitAddr), .bitIdx(bitIdx),
    .bitResult(bitResult), .flagEvent(flagEvent)
  );

  ioreg_space #(.SMALL_EE(1'b1)) uutSmall (
    .clk(clk), .rstN(rstN), .byteEn(byteEn), .byteWe(byteWe), .byteView(byteView),
    .byteAddr(byteAddr), .byteWdata(byteWdata), .byteRdata(smallRdata),
    .bitEn(bitEn), .bitOp(bitOp), .bitAddr(bitAddr), .bitIdx(bitIdx),
    .bitResult(smallBit), .flagEvent(flagEvent)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic byteWrite(input logic view, input logic [6:0] addr, input logic [7:0] data);
    @(negedge clk);
    byteEn = 1'b1; byteWe = 1'b1; byteView = view; byteAddr = addr; byteWdata = data;
    @(posedge clk); #1;
    byteEn = 1'b0; byteWe = 1'b0;
  endtask

  task automatic byteRead(input logic view, input logic [6:0] addr, output logic [7:0] data);
    @(negedge clk);
    byteEn = 1'b1; byteWe = 1'b0; byteView = view; byteAddr = addr;
    #1 data = byteRdata;
    @(posedge clk); #1;
    byteEn = 1'b0;
  endtask

  task automatic bitAccess(input logic [1:0] op, input logic [5:0] addr, input logic [2:0] idx,
                           output logic res);
    @(negedge clk);
    bitEn = 1'b1; bitOp = op; bitAddr = addr; bitIdx = idx;
    #1 res = bitResult;
    @(posedge clk); #1;
    bitEn = 1'b0; bitOp = 2'b00;
  endtask

  task automatic testReset();
    logic [7:0] d;
    byteRead(1'b0, 7'h13, d); check("R1 gpr0 reset", d, 8'h00);
    byteRead(1'b0, 7'h2A, d); check("R1 gpr1 reset", d, 8'h00);
    byteRead(1'b0, 7'h2B, d); check("R1 gpr2 reset", d, 8'h00);
    byteRead(1'b0, 7'h1C, d); check("R1 status reset", d, 8'h00);
  endtask

  task automatic testViews();
    logic [7:0] d;
    byteWrite(1'b0, 7'h13, 8'hA5);
    byteRead(1'b0, 7'h13, d); check("R5 gpr0 io readback", d, 8'hA5);
    byteRead(1'b1, 7'h33, d); check("R3 gpr0 via data view", d, 8'hA5);
    byteWrite(1'b1, 7'h4A, 8'h3C);
    byteRead(1'b0, 7'h2A, d); check("R3 gpr1 written via data view", d, 8'h3C);
    byteWrite(1'b0, 7'h2B, 8'hFF);
    byteRead(1'b1, 7'h4B, d); check("R5 gpr2 all ones", d, 8'hFF);
  endtask

  task automatic testUnmapped();
    logic [7:0] d;
    byteWrite(1'b0, 7'h05, 8'h77);
    byteRead(1'b0, 7'h05, d); check("R4 unmapped io read", d, 8'h00);
    byteWrite(1'b1, 7'h13, 8'h11);
    byteRead(1'b1, 7'h13, d); check("R3 data view below 0x20", d, 8'h00);
    byteRead(1'b1, 7'h60, d); check("R3 data view above 0x5F", d, 8'h00);
    byteWrite(1'b0, 7'h53, 8'h11);
    byteRead(1'b0, 7'h53, d); check("R2 io addr bit6 read", d, 8'h00);
    byteRead(1'b0, 7'h13, d); check("R2 R4 gpr0 untouched by unmapped writes", d, 8'hA5);
  endtask

  task automatic testBitOps();
    logic [7:0] d;
    logic r;
    bitAccess(OP_SET, 6'h13, 3'd1, r);
    byteRead(1'b0, 7'h13, d); check("R6 bit set", d, 8'hA7);
    bitAccess(OP_CLR, 6'h13, 3'd7, r);
    byteRead(1'b0, 7'h13, d); check("R6 bit clear", d, 8'h27);
    bitAccess(OP_TEST, 6'h13, 3'd2, r); check("R6 test one", {7'b0, r}, 8'h01);
    bitAccess(OP_TEST, 6'h13, 3'd3, r); check("R6 test zero", {7'b0, r}, 8'h00);
    bitAccess(OP_SET, 6'h2A, 3'd0, r);
    byteRead(1'b0, 7'h2A, d); check("R7 set above 0x1F ignored", d, 8'h3C);
    bitAccess(OP_TEST, 6'h2A, 3'd2, r); check("R7 test above 0x1F", {7'b0, r}, 8'h00);
    bitAccess(OP_SET, 6'h33, 3'd3, r);
    byteRead(1'b0, 7'h13, d); check("R7 alias 0x33 ignored", d, 8'h27);
  endtask

  task automatic testStatus();
    logic [7:0] d;
    logic r;
    @(negedge clk); flagEvent = 8'h0F;
    @(posedge clk); #1 flagEvent = 8'h00;
    byteRead(1'b0, 7'h1C, d); check("R9 event sets flags", d, 8'h0F);
    byteWrite(1'b0, 7'h1C, 8'h05);
    byteRead(1'b0, 7'h1C, d); check("R8 write one clears", d, 8'h0A);
    bitAccess(OP_SET, 6'h1C, 3'd1, r);
    byteRead(1'b0, 7'h1C, d); check("R8 bit set clears only selected", d, 8'h08);
    bitAccess(OP_CLR, 6'h1C, 3'd3, r);
    byteRead(1'b0, 7'h1C, d); check("R8 bit clear no effect", d, 8'h08);
    bitAccess(OP_TEST, 6'h1C, 3'd3, r); check("R8 flag test", {7'b0, r}, 8'h01);
    @(negedge clk);
    byteEn = 1'b1; byteWe = 1'b1; byteView = 1'b0; byteAddr = 7'h1C; byteWdata = 8'h08;
    flagEvent = 8'h08;
    @(posedge clk); #1;
    byteEn = 1'b0; byteWe = 1'b0; flagEvent = 8'h00;
    byteRead(1'b0, 7'h1C, d); check("R9 event beats clear", d, 8'h08);
    byteWrite(1'b1, 7'h3C, 8'hFF);
    byteRead(1'b0, 7'h1C, d); check("R8 clear all via data view", d, 8'h00);
  endtask

  task automatic testEeHigh();
    logic [7:0] d;
    logic r;
    byteWrite(1'b0, 7'h1F, 8'hFF);
    byteRead(1'b0, 7'h1F, d); check("R10 reserved bits zero", d, 8'h01);
    check("R10 small variant reads zero", smallRdata, 8'h00);
    bitAccess(OP_CLR, 6'h1F, 3'd0, r);
    byteRead(1'b0, 7'h1F, d); check("R10 msb bit clear", d, 8'h00);
    bitAccess(OP_SET, 6'h1F, 3'd0, r);
    bitAccess(OP_SET, 6'h1F, 3'd4, r);
    byteRead(1'b0, 7'h1F, d); check("R10 msb set, reserved stays zero", d, 8'h01);
  endtask

  task automatic testCollision();
    logic [7:0] d;
    @(negedge clk);
    byteEn = 1'b1; byteWe = 1'b1; byteView = 1'b0; byteAddr = 7'h13; byteWdata = 8'h50;
    bitEn = 1'b1; bitOp = OP_SET; bitAddr = 6'h13; bitIdx = 3'd0;
    @(posedge clk); #1;
    byteEn = 1'b0; byteWe = 1'b0; bitEn = 1'b0; bitOp = 2'b00;
    byteRead(1'b0, 7'h13, d); check("R11 byte write beats bit set", d, 8'h50);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testViews();
    testUnmapped();
    testBitOps();
    testStatus();
    testEeHigh();
    testCollision();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule